// File: doc/BRIEF.md
# Interrupt Acceptance and Gate Check Unit

This unit sits between a processor's event sources and its handler-entry sequencer. Each cycle it looks at four kinds of pending event: a synchronous exception carrying its own vector and class, a non-maskable interrupt line, a software interrupt instruction carrying a vector and the current privilege level, and a maskable hardware request carrying a vector. It picks at most one of them and registers a dispatch record. The record holds the vector to enter, the gate kind, the return-point selection, and a flag for a protection fault raised in place of the request.

The unit owns two pieces of architectural state. The first is the maskable-interrupt enable flag. Explicit set and clear commands write it, and entry through an interrupt-kind gate clears it. The second is a non-maskable block flag, which is raised on entry to the non-maskable handler and dropped by a return-from-handler pulse.

For its check, the unit presents the vector of the current winner on a lookup port. An external descriptor table answers in the same cycle with the gate kind and the gate's minimum privilege. The unit holds the dispatch record until the entry sequencer accepts it with a ready handshake. The sequencer uses the source code in the record to retire the request that won.

Top module: `evt_gate_arbiter`

## Requirements
- R1: After reset, dsp_valid is 0, if_flag is 0 and nmi_blocked is 0.
- R2: When several eligible requests are present, exactly one is accepted, in the order exception, then NMI, then software interrupt, then maskable request. dsp_src encodes the winner as exception=0, NMI=1, software=2, maskable=3.
- R3: A new event is accepted only while dsp_valid is 0. A registered record stays unchanged until a cycle with dsp_valid and dsp_ready both high, and dsp_valid then falls on the next edge.
- R4: An accepted NMI always dispatches on vector 2 and raises nmi_blocked.
- R5: While nmi_blocked is 1, no NMI, software or maskable request is accepted, but exceptions still are. An iret pulse clears nmi_blocked.
- R6: A maskable request is accepted only while if_flag is 1. A flag_set pulse sets if_flag and a flag_clr pulse clears it. When both pulses arrive in the same cycle, the clear takes effect.
- R7: A software interrupt is accepted whatever the value of if_flag.
- R8: For a software interrupt, if swi_cpl is numerically greater than gate_dpl, the dispatch carries vector 13, dsp_gp=1, return code 0 and gate kind interrupt. The privilege comparison is never applied to exceptions or maskable requests.
- R9: Gate kind is encoded interrupt=0 and trap=1. An acceptance through an interrupt gate leaves if_flag at 0 on the next cycle. An acceptance through a trap gate leaves if_flag unchanged.
- R10: dsp_ret encodes re-execute=0, next-instruction=1 and terminate=2. exc_class encodes fault=0, trap=1 and abort=2 (3 also means abort). A fault gives 0, a trap gives 1 and an abort gives 2. NMI, maskable and permitted software dispatches give 1.
- R11: While idle, lookup_vec shows, in the same cycle, the raw vector of the request that would win: the exception vector, 2 for NMI, swi_vec or irq_vec.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_req | input | 1 | Exception pending |
| exc_vec | input | 8 | Exception vector |
| exc_class | input | 2 | Exception class |
| nmi_req | input | 1 | Non-maskable interrupt pending |
| swi_req | input | 1 | Software interrupt pending |
| swi_vec | input | 8 | Software interrupt vector |
| swi_cpl | input | 2 | Current privilege level of the requester |
| irq_req | input | 1 | Maskable hardware request pending |
| irq_vec | input | 8 | Maskable request vector |
| flag_set | input | 1 | Set the enable flag |
| flag_clr | input | 1 | Clear the enable flag |
| iret | input | 1 | Return-from-handler pulse |
| lookup_vec | output | 8 | Vector presented to the descriptor table |
| gate_type | input | 1 | Gate kind for lookup_vec |
| gate_dpl | input | 2 | Gate minimum privilege for lookup_vec |
| dsp_ready | input | 1 | Entry sequencer takes the record |
| dsp_valid | output | 1 | Dispatch record valid |
| dsp_src | output | 2 | Winning source code |
| dsp_vec | output | 8 | Vector to enter |
| dsp_gate | output | 1 | Gate kind used |
| dsp_ret | output | 2 | Return-point selection |
| dsp_gp | output | 1 | Protection fault substituted |
| if_flag | output | 1 | Maskable enable flag |
| nmi_blocked | output | 1 | Non-maskable block flag |

## Verification
The hardest state to reach from the ports is a pending exception arriving while the non-maskable block is up. A higher-priority request that appears while an older record is still waiting for the handshake is similarly hard to reach. The stimulus first gets an NMI accepted and deliberately sends no iret. It then offers every other source and expects only the exception to pass. For the waiting case, it holds dsp_ready low across several cycles while an exception is raised. A sweep over all sixteen request combinations, with both flag values, covers priority. A sweep over every privilege level against every gate privilege and gate kind covers the protection fault substitution.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int N_SRC = 4;

  typedef enum logic [1:0] {
    SRC_EXC = 2'd0,
    SRC_NMI = 2'd1,
    SRC_SWI = 2'd2,
    SRC_IRQ = 2'd3
  } src_e;

  typedef enum logic {
    GATE_INTR = 1'b0,
    GATE_TRAP = 1'b1
  } gate_e;

  typedef enum logic [1:0] {
    RET_SAME = 2'd0,
    RET_NEXT = 2'd1,
    RET_TERM = 2'd2
  } ret_e;

  typedef enum logic [1:0] {
    CLS_FAULT = 2'd0,
    CLS_TRAP  = 2'd1,
    CLS_ABORT = 2'd2
  } cls_e;
endpackage

// File: rtl/evt_pick.sv
// Fixed-priority selector: index 0 is the most urgent source.
module evt_pick #(
  parameter int VEC_W = 8,
  parameter int N     = evt_pkg::N_SRC,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]            elig,
  input  logic [N-1:0][VEC_W-1:0] cand_vec,
  output logic                    any,
  output logic [IDX_W-1:0]        win_idx,
  output logic [VEC_W-1:0]        win_vec
);
  logic [N-1:0] above;
  logic [N-1:0] grant;

  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_chain
      if (i == 0) begin : g_top
        assign above[i] = 1'b0;
      end else begin : g_rest
        assign above[i] = above[i-1] | elig[i-1];
      end
      assign grant[i] = elig[i] & ~above[i];
    end
  endgenerate

  always_comb begin
    win_vec = '0;
    win_idx = '0;
    for (int k = 0; k < N; k++) begin
      if (grant[k]) begin
        win_vec = win_vec | cand_vec[k];
        win_idx = win_idx | IDX_W'(k);
      end
    end
  end

  assign any = |elig;
endmodule

// File: rtl/evt_flags.sv
// Holds the maskable enable flag and the non-maskable block flag.
module evt_flags (
  input  logic clk,
  input  logic rst,
  input  logic accept,
  input  logic accept_nmi,
  input  logic entry_clears,
  input  logic flag_set,
  input  logic flag_clr,
  input  logic iret,
  output logic if_q,
  output logic blk_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      if_q  <= 1'b0;
      blk_q <= 1'b0;
    end else begin
      if (accept && entry_clears) if_q <= 1'b0;
      else if (flag_clr)          if_q <= 1'b0;
      else if (flag_set)          if_q <= 1'b1;

      if (accept && accept_nmi) blk_q <= 1'b1;
      else if (iret)            blk_q <= 1'b0;
    end
  end
endmodule

// File: rtl/evt_decide.sv
// Privilege check, gate kind and return-point decode for the winner.
module evt_decide
  import evt_pkg::*;
#(
  parameter int VEC_W  = 8,
  parameter int PL_W   = 2,
  parameter int GP_VEC = 13
) (
  input  src_e             src,
  input  logic [VEC_W-1:0] raw_vec,
  input  logic [1:0]       exc_class,
  input  logic [PL_W-1:0]  swi_cpl,
  input  logic             gate_type,
  input  logic [PL_W-1:0]  gate_dpl,
  output logic [VEC_W-1:0] out_vec,
  output gate_e            out_gate,
  output ret_e             out_ret,
  output logic             out_gp
);
  always_comb begin
    out_gp   = (src == SRC_SWI) && (swi_cpl > gate_dpl);
    out_vec  = raw_vec;
    out_gate = gate_e'(gate_type);
    out_ret  = RET_NEXT;
    if (out_gp) begin
      out_vec  = VEC_W'(GP_VEC);
      out_gate = GATE_INTR;
      out_ret  = RET_SAME;
    end else if (src == SRC_EXC) begin
      case (exc_class)
        CLS_FAULT: out_ret = RET_SAME;
        CLS_TRAP:  out_ret = RET_NEXT;
        default:   out_ret = RET_TERM;
      endcase
    end
  end
endmodule

// File: rtl/evt_gate_arbiter.sv
module evt_gate_arbiter
  import evt_pkg::*;
#(
  parameter int VEC_W   = 8,
  parameter int PL_W    = 2,
  parameter int NMI_VEC = 2,
  parameter int GP_VEC  = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             exc_req,
  input  logic [VEC_W-1:0] exc_vec,
  input  logic [1:0]       exc_class,
  input  logic             nmi_req,
  input  logic             swi_req,
  input  logic [VEC_W-1:0] swi_vec,
  input  logic [PL_W-1:0]  swi_cpl,
  input  logic             irq_req,
  input  logic [VEC_W-1:0] irq_vec,
  input  logic             flag_set,
  input  logic             flag_clr,
  input  logic             iret,
  output logic [VEC_W-1:0] lookup_vec,
  input  logic             gate_type,
  input  logic [PL_W-1:0]  gate_dpl,
  input  logic             dsp_ready,
  output logic             dsp_valid,
  output logic [1:0]       dsp_src,
  output logic [VEC_W-1:0] dsp_vec,
  output logic             dsp_gate,
  output logic [1:0]       dsp_ret,
  output logic             dsp_gp,
  output logic             if_flag,
  output logic             nmi_blocked
);
  localparam int IDX_W = $clog2(N_SRC);

  logic [N_SRC-1:0]            elig;
  logic [N_SRC-1:0][VEC_W-1:0] cand;
  logic                        any;
  logic [IDX_W-1:0]            win_idx;
  logic [VEC_W-1:0]            raw_vec;
  logic                        accept;
  logic                        if_q, blk_q;
  logic [VEC_W-1:0]            d_vec;
  gate_e                       d_gate;
  ret_e                        d_ret;
  logic                        d_gp;
  src_e                        win_src;

  always_comb begin
    elig          = '0;
    elig[SRC_EXC] = exc_req;
    elig[SRC_NMI] = nmi_req & ~blk_q;
    elig[SRC_SWI] = swi_req & ~blk_q;
    elig[SRC_IRQ] = irq_req & if_q & ~blk_q;
    cand          = '0;
    cand[SRC_EXC] = exc_vec;
    cand[SRC_NMI] = VEC_W'(NMI_VEC);
    cand[SRC_SWI] = swi_vec;
    cand[SRC_IRQ] = irq_vec;
  end

  evt_pick #(.VEC_W(VEC_W), .N(N_SRC)) u_pick (
    .elig     (elig),
    .cand_vec (cand),
    .any      (any),
    .win_idx  (win_idx),
    .win_vec  (raw_vec)
  );

  assign win_src    = src_e'(win_idx);
  assign lookup_vec = raw_vec;
  assign accept     = any & ~dsp_valid;

  evt_decide #(.VEC_W(VEC_W), .PL_W(PL_W), .GP_VEC(GP_VEC)) u_decide (
    .src       (win_src),
    .raw_vec   (raw_vec),
    .exc_class (exc_class),
    .swi_cpl   (swi_cpl),
    .gate_type (gate_type),
    .gate_dpl  (gate_dpl),
    .out_vec   (d_vec),
    .out_gate  (d_gate),
    .out_ret   (d_ret),
    .out_gp    (d_gp)
  );

  evt_flags u_flags (
    .clk          (clk),
    .rst          (rst),
    .accept       (accept),
    .accept_nmi   (win_src == SRC_NMI),
    .entry_clears (d_gate == GATE_INTR),
    .flag_set     (flag_set),
    .flag_clr     (flag_clr),
    .iret         (iret),
    .if_q         (if_q),
    .blk_q        (blk_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dsp_valid <= 1'b0;
      dsp_src   <= '0;
      dsp_vec   <= '0;
      dsp_gate  <= 1'b0;
      dsp_ret   <= '0;
      dsp_gp    <= 1'b0;
    end else if (accept) begin
      dsp_valid <= 1'b1;
      dsp_src   <= win_src;
      dsp_vec   <= d_vec;
      dsp_gate  <= d_gate;
      dsp_ret   <= d_ret;
      dsp_gp    <= d_gp;
    end else if (dsp_valid && dsp_ready) begin
      dsp_valid <= 1'b0;
    end
  end

  assign if_flag     = if_q;
  assign nmi_blocked = blk_q;
endmodule

// File: rtl/evt_gate_chk.sv
module evt_gate_chk #(
  parameter int VEC_W   = 8,
  parameter int NMI_VEC = 2,
  parameter int GP_VEC  = 13
) (
  input logic             clk,
  input logic             rst,
  input logic             dsp_valid,
  input logic             dsp_ready,
  input logic [1:0]       dsp_src,
  input logic [VEC_W-1:0] dsp_vec,
  input logic             dsp_gate,
  input logic [1:0]       dsp_ret,
  input logic             dsp_gp,
  input logic             if_flag,
  input logic             nmi_blocked
);
  AST_HOLD_RECORD: assert property (@(posedge clk) disable iff (rst)
    dsp_valid && !dsp_ready |=> dsp_valid && $stable(dsp_vec) && $stable(dsp_src)); // R3
  AST_NMI_VECTOR: assert property (@(posedge clk) disable iff (rst)
    dsp_valid && dsp_src == 2'd1 |-> dsp_vec == VEC_W'(NMI_VEC)); // R4
  AST_NMI_SETS_BLOCK: assert property (@(posedge clk) disable iff (rst)
    $rose(dsp_valid) && dsp_src == 2'd1 |-> nmi_blocked); // R4
  AST_BLOCK_EXC_ONLY: assert property (@(posedge clk) disable iff (rst)
    $rose(dsp_valid) && $past(nmi_blocked) |-> dsp_src == 2'd0); // R5
  AST_IRQ_NEEDS_IF: assert property (@(posedge clk) disable iff (rst)
    $rose(dsp_valid) && dsp_src == 2'd3 |-> $past(if_flag)); // R6
  AST_GP_FORM: assert property (@(posedge clk) disable iff (rst)
    dsp_valid && dsp_gp |-> dsp_vec == VEC_W'(GP_VEC) && dsp_ret == 2'd0 && dsp_src == 2'd2); // R8
  AST_INTR_GATE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $rose(dsp_valid) && !dsp_gate |-> !if_flag); // R9
  AST_RET_LEGAL: assert property (@(posedge clk) disable iff (rst)
    dsp_valid |-> dsp_ret != 2'd3); // R10
endmodule

bind evt_gate_arbiter evt_gate_chk #(.VEC_W(VEC_W), .NMI_VEC(NMI_VEC), .GP_VEC(GP_VEC)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .dsp_valid   (dsp_valid),
  .dsp_ready   (dsp_ready),
  .dsp_src     (dsp_src),
  .dsp_vec     (dsp_vec),
  .dsp_gate    (dsp_gate),
  .dsp_ret     (dsp_ret),
  .dsp_gp      (dsp_gp),
  .if_flag     (if_flag),
  .nmi_blocked (nmi_blocked)
);

// File: tb/evt_gate_arbiter_tb.sv
module evt_gate_arbiter_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       exc_req, nmi_req, swi_req, irq_req;
  logic [7:0] exc_vec, swi_vec, irq_vec, lookup_vec, dsp_vec;
  logic [1:0] exc_class, swi_cpl, gate_dpl, dsp_src, dsp_ret;
  logic       flag_set, flag_clr, iret, gate_type, dsp_ready;
  logic       dsp_valid, dsp_gate, dsp_gp, if_flag, nmi_blocked;

  int checks = 0;
  int failures = 0;
  bit m_if = 0;
  bit m_blk = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Descriptor table model: odd vectors are trap gates, bits 2:1 give the privilege.
  always_comb begin
    gate_type = lookup_vec[0];
    gate_dpl  = lookup_vec[2:1];
  end

  evt_gate_arbiter u_dut (
    .clk(clk), .rst(rst),
    .exc_req(exc_req), .exc_vec(exc_vec), .exc_class(exc_class),
    .nmi_req(nmi_req),
    .swi_req(swi_req), .swi_vec(swi_vec), .swi_cpl(swi_cpl),
    .irq_req(irq_req), .irq_vec(irq_vec),
    .flag_set(flag_set), .flag_clr(flag_clr), .iret(iret),
    .lookup_vec(lookup_vec), .gate_type(gate_type), .gate_dpl(gate_dpl),
    .dsp_ready(dsp_ready), .dsp_valid(dsp_valid), .dsp_src(dsp_src),
    .dsp_vec(dsp_vec), .dsp_gate(dsp_gate), .dsp_ret(dsp_ret),
    .dsp_gp(dsp_gp), .if_flag(if_flag), .nmi_blocked(nmi_blocked)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_reqs();
    exc_req = 0; nmi_req = 0; swi_req = 0; irq_req = 0;
  endtask

  task automatic pulse_flags(input bit s, input bit c, input bit r);
    @(negedge clk);
    flag_set = s; flag_clr = c; iret = r;
    @(posedge clk);
    @(negedge clk);
    flag_set = 0; flag_clr = 0; iret = 0;
    if (c) m_if = 0; else if (s) m_if = 1;
    if (r) m_blk = 0;
    chk("R6 flag", int'(if_flag), int'(m_if));
    chk("R5 block", int'(nmi_blocked), int'(m_blk));
  endtask

  // Drive a request mix, check the registered record; returns with the record still pending.
  task automatic issue(input bit e, input bit n, input bit s, input bit q,
                       input logic [7:0] ev, input logic [1:0] ecls,
                       input logic [7:0] sv, input logic [1:0] cpl,
                       input logic [7:0] qv, input string tag, output bit got);
    int w;
    logic [7:0] raw, xv;
    bit gp, xg;
    int xr;
    @(negedge clk);
    exc_req = e; nmi_req = n; swi_req = s; irq_req = q;
    exc_vec = ev; exc_class = ecls; swi_vec = sv; swi_cpl = cpl; irq_vec = qv;
    w = -1;
    if (e) w = 0;
    else if (n && !m_blk) w = 1;
    else if (s && !m_blk) w = 2;
    else if (q && m_if && !m_blk) w = 3;
    raw = (w == 0) ? ev : (w == 1) ? 8'd2 : (w == 2) ? sv : qv;
    gp  = (w == 2) && (cpl > raw[2:1]);
    xv  = gp ? 8'd13 : raw;
    xg  = gp ? 1'b0 : raw[0];
    if (gp) xr = 0;
    else if (w == 0) xr = (ecls == 2'd0) ? 0 : (ecls == 2'd1) ? 1 : 2;
    else xr = 1;
    #1;
    if (w >= 0) chk({"R11 lookup ", tag}, int'(lookup_vec), int'(raw));
    @(posedge clk);
    @(negedge clk);
    got = (w >= 0);
    chk({"R2 valid ", tag}, int'(dsp_valid), int'(got));
    if (got) begin
      if (!xg) m_if = 0;
      if (w == 1) m_blk = 1;
      chk({"R2 src ", tag}, int'(dsp_src), w);
      chk({"R8 vec ", tag}, int'(dsp_vec), int'(xv));
      chk({"R8 gp ", tag}, int'(dsp_gp), int'(gp));
      chk({"R9 gate ", tag}, int'(dsp_gate), int'(xg));
      chk({"R10 ret ", tag}, int'(dsp_ret), xr);
      chk({"R4 blk ", tag}, int'(nmi_blocked), int'(m_blk));
    end
    chk({"R9 if ", tag}, int'(if_flag), int'(m_if));
  endtask

  task automatic ack();
    @(negedge clk);
    clear_reqs();
    dsp_ready = 1;
    @(posedge clk);
    @(negedge clk);
    dsp_ready = 0;
    chk("R3 release", int'(dsp_valid), 0);
  endtask

  task automatic go(input bit e, input bit n, input bit s, input bit q,
                    input logic [7:0] ev, input logic [1:0] ecls,
                    input logic [7:0] sv, input logic [1:0] cpl,
                    input logic [7:0] qv, input string tag);
    bit got;
    issue(e, n, s, q, ev, ecls, sv, cpl, qv, tag, got);
    if (got) ack();
    else begin
      @(negedge clk);
      clear_reqs();
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    bit got;
    rst = 1; clear_reqs();
    exc_vec = 0; exc_class = 0; swi_vec = 0; swi_cpl = 0; irq_vec = 0;
    flag_set = 0; flag_clr = 0; iret = 0; dsp_ready = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 valid", int'(dsp_valid), 0);
    chk("R1 if", int'(if_flag), 0);
    chk("R1 blk", int'(nmi_blocked), 0);

    // R6 masked while flag clear; R9 interrupt gate clears, trap gate keeps
    go(0, 0, 0, 1, 0, 0, 0, 0, 8'h40, "R6 masked");
    pulse_flags(1, 0, 0);
    go(0, 0, 0, 1, 0, 0, 0, 3, 8'h40, "R9 intr gate, R8 no dpl on irq");
    pulse_flags(1, 0, 0);
    go(0, 0, 0, 1, 0, 0, 0, 0, 8'h41, "R9 trap gate");
    // R6 clear wins over set
    pulse_flags(1, 1, 0);

    // R2 priority sweep over all request mixes and both flag values
    for (int ifv = 0; ifv < 2; ifv++) begin
      for (int m = 0; m < 16; m++) begin
        pulse_flags(ifv[0], !ifv[0], 1);
        go(m[3], m[2], m[1], m[0], 8'h05, 2'd1, 8'h87, 2'd0, 8'h51, "R2 sweep");
      end
    end

    // R7 software interrupt with flag clear; R8 privilege sweep
    for (int cpl = 0; cpl < 4; cpl++)
      for (int dpl = 0; dpl < 4; dpl++)
        for (int t = 0; t < 2; t++) begin
          pulse_flags(0, 1, 0);
          go(0, 0, 1, 0, 0, 0, 8'h80 | 8'(dpl << 1) | 8'(t), 2'(cpl), 0, "R7 R8 swi");
        end

    // R10 exception classes, R8 exceptions never checked against dpl
    for (int c = 0; c < 4; c++) begin
      pulse_flags(1, 0, 0);
      go(1, 0, 0, 0, 8'h0E | 8'(c & 1), 2'(c), 0, 2'd3, 0, "R10 class");
    end

    // R5 block: NMI, then nothing but exceptions until iret
    pulse_flags(1, 0, 0);
    go(0, 1, 0, 0, 0, 0, 0, 0, 0, "R4 nmi");
    pulse_flags(1, 0, 0);
    go(0, 1, 0, 0, 0, 0, 0, 0, 0, "R5 nmi blocked");
    go(0, 0, 1, 0, 0, 0, 8'h87, 0, 0, "R5 swi blocked");
    go(0, 0, 0, 1, 0, 0, 0, 0, 8'h41, "R5 irq blocked");
    go(1, 1, 1, 1, 8'h0D, 2'd0, 8'h87, 0, 8'h41, "R5 exc passes");
    pulse_flags(0, 0, 1);
    go(0, 1, 0, 1, 0, 0, 0, 0, 8'h41, "R5 after iret");
    pulse_flags(0, 0, 1);

    // R3 hold: record stays while a higher-priority request waits
    pulse_flags(1, 0, 0);
    issue(0, 0, 0, 1, 0, 0, 0, 0, 8'h43, "R3 first", got);
    @(negedge clk);
    irq_req = 0; exc_req = 1; exc_vec = 8'h03; exc_class = 2'd1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R3 held valid", int'(dsp_valid), 1);
    chk("R3 held src", int'(dsp_src), 3);
    chk("R3 held vec", int'(dsp_vec), 8'h43);
    ack();
    go(1, 0, 0, 0, 8'h03, 2'd1, 0, 0, 0, "R3 next");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule